// File: doc/BRIEF.md
# Instruction single-step controller

This block drives the active-high ready input of an 8-bit microprocessor. An operator can use it to let the processor run freely, to stop it, or to advance it by one whole instruction per button press. Instruction boundaries come from the processor's opcode-fetch indicator, and the read/write line decides when a stall is allowed. A run/stop switch and a step push-button are the operator inputs. Each one passes through a flop synchroniser and a counter debouncer before the control state machine sees it.

A step advances the processor to the next opcode fetch and no further. The controller acts on the rising edge of the fetch indicator, not on its level. The processor can hold that indicator high for as long as it is halted, so acting on the level would stop the processor again at once. The stall that ends a step is applied in the same cycle as the fetch, which means no instruction is skipped. A stop requested with the switch never holds a write cycle. It takes effect on the next read cycle, which can fall in the middle of an instruction. A step after such a stop runs on to the next fetch.

Top module: `insn_step_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after reset when `RUN_AT_RESET` is 0 and the switch is off, `rdy_o` is 0 and `stopped_o` is 1. Asserting `rst_ni` low clears `rdy_o` without waiting for a clock edge.
- R2: `stopped_o` is always the complement of `rdy_o`. While the controller is stopped, `rdy_o` stays 0 whatever `sync_i` and `rw_i` do.
- R3: When stopped, a debounced rising edge on `step_btn_i` starts a step. `rdy_o` is then 1 in every bus cycle until the step ends.
- R4: During a step, in a cycle where `sync_i` is 1, was 0 in the previous cycle and `rw_i` is 1 (read), `rdy_o` is 0 in that same cycle. The controller then stays stopped.
- R5: During a step, `sync_i` held at 1 with no rising edge does not end the step.
- R6: Holding `step_btn_i` gives only one step. A further step needs the button to be released and pressed again.
- R7: When the debounced `run_sw_i` is 1 (run), `rdy_o` is 1 in every cycle, fetch cycles included. Step presses have no effect in this state.
- R8: After the debounced `run_sw_i` goes to 0 (stop) while running, `rdy_o` stays 1 through write cycles (`rw_i` = 0). It drops to 0 in the first read cycle (`rw_i` = 1), even in the middle of an instruction.
- R9: After a stop in the middle of an instruction, a step keeps `rdy_o` at 1 until the next `sync_i` rising edge. It halts in that fetch cycle.
- R10: A change on `step_btn_i` or `run_sw_i` that lasts fewer than `DEB_CYCLES` consecutive synchronised cycles is ignored.
- R11: With `RUN_AT_RESET` = 1, the controller runs (`rdy_o` = 1) from the first clock edge after reset. It does this without the switch, until the switch has settled at stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Opcode-fetch indicator from the processor |
| rw_i | input | 1 | Bus direction, 1 = read, 0 = write |
| run_sw_i | input | 1 | Run/stop switch level, 1 = run |
| step_btn_i | input | 1 | Step push-button, 1 = pressed |
| rdy_o | output | 1 | Ready to the processor, 0 stalls it |
| stopped_o | output | 1 | High while the controller holds ready low |

## Verification
The bench holds the fetch indicator high through whole step sequences. A design that reacts to the level of that indicator would therefore fail to step at all, or stop again at once. The bench stops the processor during a string of write cycles: a design that ignores the bus direction would stall a write, and one that waits for a fetch would run past the read. It also checks the exact fetch cycle, where a stall one cycle late would skip an instruction. Further checks cover a held step button, a button glitch shorter than the settle time and step presses while running; a wrong design would give extra steps or stop the processor. A second instance checks the run-at-reset option.

// File: rtl/step_pkg.sv
package step_pkg;
  typedef enum logic [1:0] {
    ST_STOPPED = 2'd0,
    ST_RUN     = 2'd1,
    ST_STEP    = 2'd2
  } step_state_e;
endpackage

// File: rtl/step_in_cond.sv
// Synchroniser chain followed by a settle-counter debouncer.
module step_in_cond #(
  parameter int unsigned DEB_CYCLES  = 1000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RST_VAL     = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int unsigned CNT_W = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   lvl_q;
  logic                   samp;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= RST_VAL;
        else         sync_q[g] <= raw_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= RST_VAL;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign samp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= RST_VAL;
    end else if (samp != lvl_q) begin
      if (cnt_q == LAST) begin
        lvl_q <= samp;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign lvl_o = lvl_q;

  AST_DEB_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> ($past(cnt_q) == LAST)); // R10
endmodule

// File: rtl/step_edge.sv
// Single-cycle pulse on a rising level.
module step_edge #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= RST_VAL;
    else         q <= d_i;

  assign rise_o = d_i & ~q;
endmodule

// File: rtl/step_fsm.sv
module step_fsm
  import step_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_lvl_i,
  input  logic step_rise_i,
  input  logic sync_rise_i,
  input  logic rw_i,
  output logic rdy_o
);
  step_state_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    rdy_o = 1'b0;
    unique case (st_q)
      ST_STOPPED: begin
        if (run_lvl_i)        st_d = ST_RUN;
        else if (step_rise_i) st_d = ST_STEP;
      end
      ST_RUN: begin
        // stop waits for a read cycle; writes always complete
        if (!run_lvl_i && rw_i) st_d = ST_STOPPED;
        else                    rdy_o = 1'b1;
      end
      ST_STEP: begin
        // halt inside the fetch cycle itself, not the one after
        if (sync_rise_i && rw_i) st_d = ST_STOPPED;
        else begin
          rdy_o = 1'b1;
          if (run_lvl_i) st_d = ST_RUN;
        end
      end
      default: st_d = ST_STOPPED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_STOPPED;
    else         st_q <= st_d;

  AST_NO_WRITE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_STOPPED && !rw_i) |-> rdy_o); // R8

  AST_FETCH_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STEP && sync_rise_i && rw_i) |=> (st_q == ST_STOPPED)); // R4

  AST_STOP_EXIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STOPPED) |=> (st_q == ST_STOPPED || $past(run_lvl_i) || $past(step_rise_i))); // R3

  AST_RUN_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && run_lvl_i) |-> rdy_o); // R7
endmodule

// File: rtl/insn_step_ctrl.sv
module insn_step_ctrl #(
  parameter int unsigned DEB_CYCLES   = 1000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter bit          RUN_AT_RESET = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic rw_i,
  input  logic run_sw_i,
  input  logic step_btn_i,
  output logic rdy_o,
  output logic stopped_o
);
  logic run_lvl, step_lvl, step_rise, sync_rise, rdy;

  step_in_cond #(
    .DEB_CYCLES(DEB_CYCLES), .SYNC_STAGES(SYNC_STAGES), .RST_VAL(RUN_AT_RESET)
  ) u_run_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(run_sw_i), .lvl_o(run_lvl)
  );

  step_in_cond #(
    .DEB_CYCLES(DEB_CYCLES), .SYNC_STAGES(SYNC_STAGES), .RST_VAL(1'b0)
  ) u_step_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(step_btn_i), .lvl_o(step_lvl)
  );

  step_edge #(.RST_VAL(1'b0)) u_step_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(step_lvl), .rise_o(step_rise)
  );

  // fetch indicator is already clock-synchronous; only its edge is used
  step_edge #(.RST_VAL(1'b1)) u_sync_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_i), .rise_o(sync_rise)
  );

  step_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_lvl_i(run_lvl), .step_rise_i(step_rise),
    .sync_rise_i(sync_rise), .rw_i(rw_i), .rdy_o(rdy)
  );

  assign rdy_o     = rdy;
  assign stopped_o = ~rdy;
endmodule

// File: tb/tb_insn_step_ctrl.sv
module tb_insn_step_ctrl;
  localparam int DEB = 4;
  localparam int SETTLE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0, rw = 1'b1, run_sw = 1'b0, step_btn = 1'b0;
  logic rdy, stopped, rdy2, stopped2;
  int n_chk = 0, n_fail = 0;

  bit    q_rdy[$];
  bit    q_chk2[$];
  bit    q_rdy2[$];
  string q_tag[$];

  always #5 clk = ~clk;

  insn_step_ctrl #(.DEB_CYCLES(DEB), .SYNC_STAGES(2), .RUN_AT_RESET(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .rw_i(rw), .run_sw_i(run_sw),
    .step_btn_i(step_btn), .rdy_o(rdy), .stopped_o(stopped)
  );

  insn_step_ctrl #(.DEB_CYCLES(DEB), .SYNC_STAGES(2), .RUN_AT_RESET(1'b1)) dut_r (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .rw_i(rw), .run_sw_i(1'b0),
    .step_btn_i(1'b0), .rdy_o(rdy2), .stopped_o(stopped2)
  );

  task automatic put(input bit s, input bit w, input bit er, input bit c2, input bit er2,
                     input string tag);
    @(negedge clk);
    sync = s; rw = w;
    q_rdy.push_back(er); q_chk2.push_back(c2); q_rdy2.push_back(er2); q_tag.push_back(tag);
  endtask

  task automatic cyc(input bit s, input bit w, input bit er, input string tag);
    put(s, w, er, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input int n, input bit s, input bit w);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync = s; rw = w;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: compare just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (q_rdy.size() > 0) begin
        bit er, c2, er2;
        string tag;
        er = q_rdy.pop_front(); c2 = q_chk2.pop_front();
        er2 = q_rdy2.pop_front(); tag = q_tag.pop_front();
        n_chk++;
        if (rdy !== er || stopped !== !er) begin
          n_fail++;
          $display("FAIL %s: rdy_o=%0b stopped_o=%0b expected rdy_o=%0b stopped_o=%0b",
                   tag, rdy, stopped, er, !er);
        end
        if (c2) begin
          n_chk++;
          if (rdy2 !== er2 || stopped2 !== !er2) begin
            n_fail++;
            $display("FAIL %s (run-at-reset): rdy_o=%0b expected %0b", tag, rdy2, er2);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    // R1 reset state
    cyc(1'b0, 1'b1, 1'b0, "R1 during reset");
    put(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R1 during reset, R11 held");
    @(negedge clk); rst_n = 1'b1; sync = 1'b0; rw = 1'b1;
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R1 stopped after reset, R11 running");
    put(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R2 stopped ignores fetch, R11 running");
    put(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R2 stopped ignores write, R11 running");
    idle(6, 1'b0, 1'b1);
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2 still stopped, R11 switch stop settled");

    // R3/R4/R5 step with fetch indicator held high
    step_btn = 1'b1;
    idle(SETTLE, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, "R5 held fetch level does not halt");
    cyc(1'b0, 1'b1, 1'b1, "R3 step read");
    cyc(1'b0, 1'b0, 1'b1, "R3 step write");
    cyc(1'b1, 1'b1, 1'b0, "R4 halt in fetch cycle");
    cyc(1'b1, 1'b1, 1'b0, "R4 stays halted");
    idle(6, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, "R6 held button no second step");

    // R6 release and press again
    step_btn = 1'b0;
    idle(SETTLE, 1'b1, 1'b1);
    step_btn = 1'b1;
    idle(SETTLE, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, "R6 re-press steps");
    cyc(1'b0, 1'b0, 1'b1, "R6 step write");
    cyc(1'b1, 1'b1, 1'b0, "R4 second halt at fetch");
    step_btn = 1'b0;
    idle(SETTLE, 1'b0, 1'b1);

    // R10 short glitch on step button
    step_btn = 1'b1;
    idle(2, 1'b0, 1'b1);
    step_btn = 1'b0;
    idle(10, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, "R10 glitch ignored");
    cyc(1'b1, 1'b1, 1'b0, "R10 glitch ignored at fetch");

    // R7 run
    run_sw = 1'b1;
    idle(SETTLE, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, "R7 fetch passes while running");
    cyc(1'b0, 1'b1, 1'b1, "R7 read");
    cyc(1'b0, 1'b0, 1'b1, "R7 write");
    cyc(1'b1, 1'b1, 1'b1, "R7 second fetch");
    step_btn = 1'b1;
    idle(SETTLE, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, "R7 step press ignored");
    step_btn = 1'b0;
    idle(SETTLE, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, "R7 step release ignored");

    // R10 short glitch on run switch
    run_sw = 1'b0;
    idle(2, 1'b0, 1'b1);
    run_sw = 1'b1;
    idle(10, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, "R10 run glitch ignored");

    // R8 stop during writes
    run_sw = 1'b0;
    idle(SETTLE, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, "R8 write not stalled");
    cyc(1'b0, 1'b0, 1'b1, "R8 second write not stalled");
    cyc(1'b0, 1'b1, 1'b0, "R8 stop on first read");
    cyc(1'b0, 1'b1, 1'b0, "R8 stays stopped");
    cyc(1'b1, 1'b1, 1'b0, "R2 stopped ignores fetch");

    // R9 step from mid-instruction stop
    step_btn = 1'b1;
    idle(SETTLE, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, "R9 continues read");
    cyc(1'b0, 1'b0, 1'b1, "R9 continues write");
    cyc(1'b1, 1'b1, 1'b0, "R9 halt at next fetch");
    step_btn = 1'b0;
    idle(SETTLE, 1'b0, 1'b1);

    // R1 asynchronous reset while running
    run_sw = 1'b1;
    idle(SETTLE, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, "R7 running before reset");
    while (q_rdy.size() > 0) @(negedge clk);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    n_chk++;
    if (rdy !== 1'b0 || stopped !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 async reset: rdy_o=%0b expected 0", rdy);
    end
    idle(3, 1'b0, 1'b1);
    summary();
  end
endmodule